// File: doc/BRIEF.md
# Constant-On-Time Switching Sequencer

This block is the digital timing core of a constant-on-time step-down regulator. It turns a handful of comparator flags into the two gate commands of a synchronous buck stage. A new switching cycle opens only when the output is asking for energy (error flag high), the valley current is under its limit, and a minimum off-time has run out. The high-side gate then stays on for a programmed number of clocks. After that, the low-side gate takes over, with a dead gap of a few clocks at every hand-over.

Two light-load behaviours are supported. In automatic mode, a zero-crossing flag cuts low-side conduction short, and both switches then rest until the next cycle opens. In forced mode the zero-crossing flag is ignored, so the low-side gate follows the inverse of the high-side gate except during dead gaps. Two override inputs serve the protection logic. One turns both gates off. The other parks the stage with the low-side switch on.

Top module: `cot_timing_ctrl`

## Requirements
- R1: After a synchronous reset, both gates are low and no off-time is pending, so the first cycle may open as soon as its other conditions hold.
- R2: A cycle opens only when `run` is 1, `err_hi` is 1, `ilim` is 0 and the minimum off-time has expired. After `DEAD` clocks with both gates low, `hs_gate` rises.
- R3: The high-side pulse lasts exactly max(`ton_cycles`, `TON_MIN`) clocks, using the `ton_cycles` value sampled in the clock where the cycle opens, unless an override or `run`=0 cuts it short.
- R4: With `fpwm`=0 (automatic mode), `zc`=1 while the low-side gate is on turns `ls_gate` off on the next clock. Both gates then stay low until a new cycle opens.
- R5: With `fpwm`=1 (forced mode), `zc` has no effect. Once on, `ls_gate` stays on until a new cycle opens or an override or `run`=0 acts.
- R6: `hs_gate` and `ls_gate` are never high together. Each gate rises only after the other has been low for at least `DEAD` clocks.
- R7: After `hs_gate` falls, it stays low for at least `TOFF_MIN` clocks.
- R8: While `ilim` is 1, no new cycle opens.
- R9: `force_off`=1 drives both gates low from the next clock and holds them low while it stays asserted. It takes priority over `force_lo`.
- R10: `force_lo`=1 (with `force_off`=0) drives `hs_gate` low from the next clock. `ls_gate` comes on after `DEAD` clocks, then stays on regardless of `zc`, and no cycle opens.
- R11: `run`=0 drives both gates low from the next clock and keeps them low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable; 0 parks both gates off |
| err_hi | input | 1 | Error comparator: output below target |
| ilim | input | 1 | Valley current above limit |
| zc | input | 1 | Inductor current zero crossing |
| fpwm | input | 1 | 1 = forced mode, 0 = automatic mode |
| ton_cycles | input | TON_W | Requested on-time in clocks |
| force_off | input | 1 | Protection: both gates off |
| force_lo | input | 1 | Protection: low-side on, high-side off |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
The bound checker watches the gate pair on every clock. It flags any overlap, any rise that comes without a dead gap, any high-side pulse shorter than the minimum that was not cut by an override, and any off gap shorter than the minimum. It also checks the one-clock response to both overrides and to `run`, and that a forced-mode low-side gate releases only for a cycle that the error flag opened. The exact on-time values, including clamping, the need for all three opening conditions together, the resting state after a zero crossing in automatic mode, and the indifference to `zc` in forced mode can be shown only by the bench. It does this with directed scenarios and a clock-by-clock behavioural model.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DTH  = 3'd1,
    ST_HIGH = 3'd2,
    ST_DTL  = 3'd3,
    ST_LOW  = 3'd4
  } cot_state_e;
endpackage

// File: rtl/cot_down_counter.sv
module cot_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/cot_ontime_clamp.sv
module cot_ontime_clamp #(
  parameter int TON_W   = 10,
  parameter int TON_MIN = 28
) (
  input  logic [TON_W-1:0] ton_req,
  output logic [TON_W-1:0] ton_eff
);
  localparam logic [TON_W-1:0] FLOOR = TON_W'(TON_MIN);

  always_comb begin
    if (ton_req < FLOOR) ton_eff = FLOOR;
    else                 ton_eff = ton_req;
  end
endmodule

// File: rtl/cot_seq_fsm.sv
module cot_seq_fsm
  import cot_pkg::*;
#(
  parameter int TON_W = 10,
  parameter int DEAD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             hold_lo,
  input  logic             trig,
  input  logic             zc_end,
  input  logic [TON_W-1:0] ton_eff,
  output cot_state_e       nstate,
  output logic             leave_high
);
  localparam logic [TON_W-1:0] DEAD_M1 = TON_W'(DEAD - 1);

  cot_state_e       state;
  logic [TON_W-1:0] cnt, cnt_n, dec;
  logic [TON_W-1:0] ton_lat, ton_lat_n;

  always_comb begin
    dec       = (cnt != '0) ? cnt - 1'b1 : cnt;
    nstate    = state;
    cnt_n     = dec;
    ton_lat_n = ton_lat;
    if (kill) begin
      nstate = ST_IDLE;
      cnt_n  = '0;
    end else if (hold_lo && state != ST_DTL && state != ST_LOW) begin
      nstate = ST_DTL;
      cnt_n  = DEAD_M1;
    end else begin
      unique case (state)
        ST_IDLE: if (trig) begin
          nstate    = ST_DTH;
          cnt_n     = DEAD_M1;
          ton_lat_n = ton_eff;
        end
        ST_DTH: if (cnt == '0) begin
          nstate = ST_HIGH;
          cnt_n  = ton_lat - 1'b1;
        end
        ST_HIGH: if (cnt == '0) begin
          nstate = ST_DTL;
          cnt_n  = DEAD_M1;
        end
        ST_DTL: if (cnt == '0) nstate = ST_LOW;
        ST_LOW: begin
          if (hold_lo) begin
            nstate = ST_LOW;
          end else if (trig) begin
            nstate    = ST_DTH;
            cnt_n     = DEAD_M1;
            ton_lat_n = ton_eff;
          end else if (zc_end) begin
            nstate = ST_IDLE;
          end
        end
        default: nstate = ST_IDLE;
      endcase
    end
  end

  assign leave_high = (state == ST_HIGH) && (nstate != ST_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ton_lat <= '0;
    end else begin
      state   <= nstate;
      cnt     <= cnt_n;
      ton_lat <= ton_lat_n;
    end
  end
endmodule

// File: rtl/cot_timing_ctrl.sv
module cot_timing_ctrl
  import cot_pkg::*;
#(
  parameter int TON_W    = 10,
  parameter int TON_MIN  = 28,
  parameter int TOFF_MIN = 112,
  parameter int DEAD     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             err_hi,
  input  logic             ilim,
  input  logic             zc,
  input  logic             fpwm,
  input  logic [TON_W-1:0] ton_cycles,
  input  logic             force_off,
  input  logic             force_lo,
  output logic             hs_gate,
  output logic             ls_gate
);
  localparam int TOFF_W = $clog2(TOFF_MIN + 1);
  localparam logic [TOFF_W-1:0] TOFF_LOAD = TOFF_W'(TOFF_MIN - 1);

  logic             kill, trig, zc_end, toff_done, leave_high;
  logic [TON_W-1:0] ton_eff;
  cot_state_e       nstate;

  assign kill   = force_off | ~run;
  assign trig   = err_hi & ~ilim & toff_done;
  assign zc_end = zc & ~fpwm;

  cot_ontime_clamp #(.TON_W(TON_W), .TON_MIN(TON_MIN)) u_clamp (
    .ton_req (ton_cycles),
    .ton_eff (ton_eff)
  );

  cot_down_counter #(.W(TOFF_W)) u_toff (
    .clk      (clk),
    .rst      (rst),
    .load     (leave_high),
    .load_val (TOFF_LOAD),
    .done     (toff_done)
  );

  cot_seq_fsm #(.TON_W(TON_W), .DEAD(DEAD)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .kill       (kill),
    .hold_lo    (force_lo),
    .trig       (trig),
    .zc_end     (zc_end),
    .ton_eff    (ton_eff),
    .nstate     (nstate),
    .leave_high (leave_high)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
    end else begin
      hs_gate <= (nstate == ST_HIGH);
      ls_gate <= (nstate == ST_LOW);
    end
  end
endmodule

// File: rtl/cot_timing_ctrl_chk.sv
module cot_timing_ctrl_chk #(
  parameter int TON_MIN  = 28,
  parameter int TOFF_MIN = 112,
  parameter int DEAD     = 2
) (
  input logic clk,
  input logic rst,
  input logic run,
  input logic err_hi,
  input logic fpwm,
  input logic force_off,
  input logic force_lo,
  input logic hs_gate,
  input logic ls_gate
);
  localparam int SAT0 = (TOFF_MIN > TON_MIN) ? TOFF_MIN : TON_MIN;
  localparam int SAT  = (SAT0 > DEAD) ? SAT0 : DEAD;
  localparam int CW   = $clog2(SAT + 1);
  localparam logic [CW-1:0] C_SAT  = CW'(SAT);
  localparam logic [CW-1:0] C_DEAD = CW'(DEAD);
  localparam logic [CW-1:0] C_TON  = CW'(TON_MIN);
  localparam logic [CW-1:0] C_TOFF = CW'(TOFF_MIN);

  logic [CW-1:0] hs_lo_run, ls_lo_run, hs_hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_lo_run <= C_SAT;
      ls_lo_run <= C_SAT;
      hs_hi_run <= '0;
    end else begin
      hs_lo_run <= hs_gate ? '0 : ((hs_lo_run == C_SAT) ? C_SAT : hs_lo_run + 1'b1);
      ls_lo_run <= ls_gate ? '0 : ((ls_lo_run == C_SAT) ? C_SAT : ls_lo_run + 1'b1);
      hs_hi_run <= !hs_gate ? '0 : ((hs_hi_run == C_SAT) ? C_SAT : hs_hi_run + 1'b1);
    end
  end

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));
  a_r6_dead_before_hs: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> ls_lo_run >= C_DEAD);
  a_r6_dead_before_ls: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> hs_lo_run >= C_DEAD);
  a_r7_min_off: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> hs_lo_run >= C_TOFF);
  a_r3_min_on: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_gate) && $past(run) && !$past(force_off) && !$past(force_lo))
      |-> hs_hi_run >= C_TON);
  a_r9_force_off: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (!hs_gate && !ls_gate));
  a_r11_run_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!hs_gate && !ls_gate));
  a_r10_force_lo_hs: assert property (@(posedge clk) disable iff (rst)
    force_lo |=> !hs_gate);
  a_r5_forced_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(ls_gate) && $past(fpwm) && $past(run) && !$past(force_off))
      |-> $past(err_hi));
endmodule

bind cot_timing_ctrl cot_timing_ctrl_chk #(
  .TON_MIN  (TON_MIN),
  .TOFF_MIN (TOFF_MIN),
  .DEAD     (DEAD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .err_hi    (err_hi),
  .fpwm      (fpwm),
  .force_off (force_off),
  .force_lo  (force_lo),
  .hs_gate   (hs_gate),
  .ls_gate   (ls_gate)
);

// File: tb/cot_timing_ctrl_tb.sv
module cot_timing_ctrl_tb;
  localparam int TON_W    = 10;
  localparam int TON_MIN  = 28;
  localparam int TOFF_MIN = 112;
  localparam int DEAD     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0, err_hi = 1'b0, ilim = 1'b0, zc = 1'b0, fpwm = 1'b0;
  logic force_off = 1'b0, force_lo = 1'b0;
  logic [TON_W-1:0] ton_cycles = '0;
  logic hs_gate, ls_gate;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cot_timing_ctrl #(.TON_W(TON_W), .TON_MIN(TON_MIN), .TOFF_MIN(TOFF_MIN), .DEAD(DEAD)) u_dut (
    .clk(clk), .rst(rst), .run(run), .err_hi(err_hi), .ilim(ilim), .zc(zc),
    .fpwm(fpwm), .ton_cycles(ton_cycles), .force_off(force_off),
    .force_lo(force_lo), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 rest, 1 gap before high, 2 high, 3 gap after high, 4 low
  int ph = 0, tmr = 0, offl = 0, lat = 0, np = 0, nt = 0;
  bit trg;
  logic m_hs = 1'b0, m_ls = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; tmr = 0; offl = 0; lat = 0;
    end else begin
      trg = err_hi && !ilim && (offl == 0);
      np = ph;
      nt = (tmr > 0) ? tmr - 1 : 0;
      if (!run || force_off) begin
        np = 0; nt = 0;
      end else if (force_lo && ph != 3 && ph != 4) begin
        np = 3; nt = DEAD - 1;
      end else begin
        case (ph)
          0: if (trg) begin np = 1; nt = DEAD - 1; lat = (int'(ton_cycles) < TON_MIN) ? TON_MIN : int'(ton_cycles); end
          1: if (tmr == 0) begin np = 2; nt = lat - 1; end
          2: if (tmr == 0) begin np = 3; nt = DEAD - 1; end
          3: if (tmr == 0) np = 4;
          default: begin
            if (force_lo) np = 4;
            else if (trg) begin np = 1; nt = DEAD - 1; lat = (int'(ton_cycles) < TON_MIN) ? TON_MIN : int'(ton_cycles); end
            else if (!fpwm && zc) np = 0;
          end
        endcase
      end
      if (ph == 2 && np != 2) offl = TOFF_MIN - 1;
      else if (offl > 0) offl = offl - 1;
      ph = np; tmr = nt;
    end
    m_hs = (ph == 2);
    m_ls = (ph == 4);
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      string tg;
      case (ph)
        2: tg = "R3";
        1, 3: tg = "R6";
        4: tg = fpwm ? "R5" : "R4";
        default: tg = "R2";
      endcase
      chk(hs_gate === m_hs, {tg, " hs_gate vs model"}, int'(hs_gate), int'(m_hs));
      chk(ls_gate === m_ls, {tg, " ls_gate vs model"}, int'(ls_gate), int'(m_ls));
    end
  end

  // output-side measurements
  int hw_run = 0, last_hw = 0, hs_lo = 1000, ls_lo = 1000, min_gap = 1000;
  int min_dead = 1000, overlap = 0, hi_seen = 0, ls_hi_seen = 0, ls_lo_seen = 0;
  bit seen_high = 1'b0;
  logic p_hs = 1'b0, p_ls = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (hs_gate && ls_gate) overlap++;
      if (hs_gate) hi_seen++;
      if (ls_gate) ls_hi_seen++; else ls_lo_seen++;
      if (hs_gate && !p_hs) begin
        if (seen_high && hs_lo < min_gap) min_gap = hs_lo;
        if (ls_lo < min_dead) min_dead = ls_lo;
        seen_high = 1'b1;
      end
      if (ls_gate && !p_ls && hs_lo < min_dead) min_dead = hs_lo;
      if (!hs_gate && p_hs) last_hw = hw_run;
      hw_run = hs_gate ? hw_run + 1 : 0;
      hs_lo  = hs_gate ? 0 : hs_lo + 1;
      ls_lo  = ls_gate ? 0 : ls_lo + 1;
      p_hs = hs_gate;
      p_ls = ls_gate;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_hs();
    do @(negedge clk); while (!hs_gate);
  endtask

  task automatic wait_ls();
    do @(negedge clk); while (!ls_gate);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!hs_gate && !ls_gate, "R1 gates after reset", int'({hs_gate, ls_gate}), 0);

    // R2: no error demand, no cycle
    run = 1'b1; ton_cycles = 10'd50;
    hi_seen = 0;
    repeat (100) @(negedge clk);
    chk(hi_seen == 0, "R2 idle without err_hi", hi_seen, 0);

    // R8: current limit blocks opening
    err_hi = 1'b1; ilim = 1'b1;
    repeat (100) @(negedge clk);
    chk(hi_seen == 0, "R8 ilim blocks cycle", hi_seen, 0);

    // R2/R1: limit released, cycle opens with no off-time pending
    ilim = 1'b0;
    repeat (DEAD + 2) @(negedge clk);
    chk(hi_seen > 0, "R2 opens after ilim clears", hi_seen, 1);

    // R3: programmed width
    repeat (600) @(negedge clk);
    chk(last_hw == 50, "R3 high width", last_hw, 50);

    // R3: clamp to minimum
    ton_cycles = 10'd5;
    repeat (500) @(negedge clk);
    chk(last_hw == TON_MIN, "R3 clamped width", last_hw, TON_MIN);

    // R8: limit mid-run stops further cycles
    ilim = 1'b1;
    repeat (200) @(negedge clk);
    hi_seen = 0;
    repeat (200) @(negedge clk);
    chk(hi_seen == 0, "R8 ilim held", hi_seen, 0);
    ilim = 1'b0; ton_cycles = 10'd40;

    // R4: zero crossing in automatic mode
    wait_ls();
    err_hi = 1'b0; zc = 1'b1;
    @(negedge clk);
    chk(!ls_gate && !hs_gate, "R4 zc ends low side", int'({hs_gate, ls_gate}), 0);
    zc = 1'b0;
    hi_seen = 0; ls_hi_seen = 0;
    repeat (150) @(negedge clk);
    chk(hi_seen == 0 && ls_hi_seen == 0, "R4 both rest", hi_seen + ls_hi_seen, 0);

    // R5: forced mode ignores zc
    fpwm = 1'b1; err_hi = 1'b1;
    wait_ls();
    err_hi = 1'b0; zc = 1'b1;
    ls_lo_seen = 0;
    repeat (60) @(negedge clk);
    chk(ls_lo_seen == 0, "R5 zc ignored in forced", ls_lo_seen, 0);
    zc = 1'b0; err_hi = 1'b1;
    repeat (400) @(negedge clk);

    // R9: force_off
    wait_hs();
    force_off = 1'b1;
    @(negedge clk);
    chk(!hs_gate && !ls_gate, "R9 force_off next clock", int'({hs_gate, ls_gate}), 0);
    hi_seen = 0; ls_hi_seen = 0;
    repeat (50) @(negedge clk);
    chk(hi_seen == 0 && ls_hi_seen == 0, "R9 held off", hi_seen + ls_hi_seen, 0);
    force_off = 1'b0; fpwm = 1'b0;

    // R10: force_lo
    wait_hs();
    force_lo = 1'b1; zc = 1'b1;
    @(negedge clk);
    chk(!hs_gate, "R10 hs off next clock", int'(hs_gate), 0);
    repeat (DEAD) @(negedge clk);
    chk(ls_gate, "R10 ls on after dead time", int'(ls_gate), 1);
    hi_seen = 0; ls_lo_seen = 0;
    repeat (300) @(negedge clk);
    chk(hi_seen == 0 && ls_lo_seen == 0, "R10 parked low", hi_seen + ls_lo_seen, 0);
    force_lo = 1'b0; zc = 1'b0;
    repeat (400) @(negedge clk);

    // R11: run low
    run = 1'b0;
    @(negedge clk);
    chk(!hs_gate && !ls_gate, "R11 run low", int'({hs_gate, ls_gate}), 0);
    hi_seen = 0; ls_hi_seen = 0;
    repeat (50) @(negedge clk);
    chk(hi_seen == 0 && ls_hi_seen == 0, "R11 stays off", hi_seen + ls_hi_seen, 0);

    // R6, R7: measured over the whole run
    chk(overlap == 0, "R6 overlap", overlap, 0);
    chk(min_dead >= DEAD, "R6 dead gap", min_dead, DEAD);
    chk(min_gap >= TOFF_MIN, "R7 min off", min_gap, TOFF_MIN);

    finish_run();
  end
endmodule